// File: doc/BRIEF.md
# Tagged Operand Matching and Firing Unit

This block is the heart of a tag-driven dataflow processing element. No program counter exists: an instruction runs as soon as both of its operands are present. Each arriving token names the instruction that consumes it (a tag), says which operand it supplies (left or right) and carries a data value. The unit searches a small associative store of waiting tokens for a partner of the same tag on the opposite side. If no partner is there, the token parks in the store. If a partner is found, the two leave the store together and the instruction is fired.

Firing reads the instruction word for that tag from a writable program store, applies its operation (add, subtract, multiply or pass) and forms up to two result tokens addressed to successor instructions. These result tokens leave on two output lanes and are meant to be routed, by logic outside this block, back to this or another element. An instruction may also carry an immediate constant; it then fires on a single token and never uses the store. When a token has to park and the store is full, the input is held off. A second token for the same tag and side while the first still waits is a protocol violation and sets a sticky error flag.

Top module: `dfm_unit`

## Requirements
- R1: After reset, before any token is offered, `res_valid` is 0, `dup_err` is 0, the store is empty, and `tok_ready` is 1 once the program store holds defined words.
- R2: A token for a two-operand instruction (immediate enable 0) with no partner waiting (same tag, opposite port) is stored and produces no result token.
- R3: A token that meets its waiting partner removes it and fires; when the token is accepted at clock edge k, the result tokens are on the outputs from clock edge k+1.
- R4: The token on port 0 is the first operand and port 1 the second; opcode 0 adds, 1 subtracts (first minus second), 2 multiplies and 3 passes the first operand; results keep the low 16 bits.
- R5: An instruction with immediate enable set fires on any single accepted token, using the token's value as the first operand and the immediate as the second, and leaves the store unchanged.
- R6: Result lane l (0 or 1) is valid only if destination enable bit l of the fired instruction is set, and carries destination tag bits [5l+4:5l] and port bit l from the instruction word.
- R7: The store holds 16 waiting tokens; `tok_ready` is 0 exactly when the offered token would need to be stored and the store is full; a token that matches, or targets an immediate instruction, is accepted while the store is full.
- R8: A token whose tag and port equal those of a waiting token sets `dup_err`, which stays set until reset; that token is dropped and the waiting token is kept.
- R9: With a suitable program, the unit evaluates f = a*d with a = (b+1)*(b-c) and d = c*e from tokens carrying b, c and e, with results fed back to its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Input token offered |
| tok_tag | input | 5 | Consuming instruction tag |
| tok_port | input | 1 | Operand side: 0 first, 1 second |
| tok_data | input | 16 | Operand value |
| tok_ready | output | 1 | Token accepted when high together with tok_valid |
| pw_en | input | 1 | Program store write strobe |
| pw_addr | input | 5 | Instruction tag written |
| pw_op | input | 2 | Opcode |
| pw_imm_en | input | 1 | Instruction uses immediate, fires on one token |
| pw_imm | input | 16 | Immediate second operand |
| pw_dst_en | input | 2 | Destination enable per lane |
| pw_dst_tag | input | 10 | Destination tags, lane l at bits [5l+4:5l] |
| pw_dst_port | input | 2 | Destination port per lane |
| res_valid | output | 2 | Result token valid per lane |
| res_tag | output | 10 | Result destination tags, lane l at bits [5l+4:5l] |
| res_port | output | 2 | Result destination port per lane |
| res_data | output | 32 | Result values, lane l at bits [16l+15:16l] |
| dup_err | output | 1 | Sticky duplicate-token error |

## Verification
The bench targets operand order: tokens arrive right-before-left and left-before-right for the subtracting node, and a design that paired operands by arrival order instead of by port would return a negated difference. It fills the store to exactly sixteen waiting tokens and then offers one more parking token, a matching token and an immediate token; a design with an off-by-one capacity would either drop a token or stall a partner that needs no space. A duplicate token followed by its partner exposes a store that overwrote the first value or kept both copies, and wrapping graph values expose a multiplier that did not truncate to 16 bits.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
  localparam int TAG_W  = 5;
  localparam int DATA_W = 16;
  localparam int NLANE  = 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_PASS = 2'd3
  } op_e;

  typedef struct packed {
    op_e                          op;
    logic                         imm_en;
    logic [DATA_W-1:0]            imm;
    logic [NLANE-1:0]             d_en;
    logic [NLANE-1:0][TAG_W-1:0]  d_tag;
    logic [NLANE-1:0]             d_port;
  } instr_t;

  // Operation applied on firing; results wrap to DATA_W bits.
  function automatic logic [DATA_W-1:0] dfm_alu(op_e op, logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_MUL:  r = a * b;
      default: r = a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dfm_prog_store.sv
module dfm_prog_store
  import dfm_pkg::*;
#(
  localparam int N = 1 << TAG_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_addr,
  input  instr_t           wr_data,
  input  logic [TAG_W-1:0] ra_addr,
  output instr_t           ra_data,
  input  logic [TAG_W-1:0] rb_addr,
  output instr_t           rb_data
);
  instr_t mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/dfm_match_store.sv
module dfm_match_store
  import dfm_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  q_tag,
  input  logic              q_port,
  input  logic [DATA_W-1:0] q_data,
  input  logic              ins_en,
  input  logic              rm_en,
  output logic              hit,
  output logic              dup,
  output logic [DATA_W-1:0] hit_data,
  output logic              full,
  output logic [CW-1:0]     occ
);
  logic [DEPTH-1:0]  ent_v;
  logic [DEPTH-1:0]  ent_port;
  logic [TAG_W-1:0]  ent_tag  [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [DEPTH-1:0]  hit_vec, dup_vec;
  logic [IW-1:0]     free_idx;

  always_comb begin
    hit_vec  = '0;
    dup_vec  = '0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      hit_vec[i] = ent_v[i] && (ent_tag[i] == q_tag) && (ent_port[i] != q_port);
      dup_vec[i] = ent_v[i] && (ent_tag[i] == q_tag) && (ent_port[i] == q_port);
      hit_data   = hit_data | (ent_data[i] & {DATA_W{hit_vec[i]}});
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_v[i]) free_idx = IW'(i);
    end
  end

  assign hit  = |hit_vec;
  assign dup  = |dup_vec;
  assign occ  = CW'($countones(ent_v));
  assign full = (occ == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rm_en && hit_vec[i]) ent_v[i] <= 1'b0;
      end
      if (ins_en) ent_v[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      ent_tag[free_idx]  <= q_tag;
      ent_port[free_idx] <= q_port;
      ent_data[free_idx] <= q_data;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);
  p_one_partner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_park_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |=> occ == CW'($past(occ) + 1'b1));
  p_pair_shrinks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rm_en |=> occ == CW'($past(occ) - 1'b1));
endmodule

// File: rtl/dfm_exec.sv
module dfm_exec
  import dfm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         f_valid,
  input  logic [DATA_W-1:0]            f_a,
  input  logic [DATA_W-1:0]            f_b,
  input  instr_t                       ins,
  output logic [NLANE-1:0]             o_valid,
  output logic [NLANE-1:0][TAG_W-1:0]  o_tag,
  output logic [NLANE-1:0]             o_port,
  output logic [NLANE-1:0][DATA_W-1:0] o_data
);
  logic [DATA_W-1:0] result;
  assign result = dfm_alu(ins.op, f_a, f_b);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        o_valid[l] <= 1'b0;
        o_tag[l]   <= '0;
        o_port[l]  <= 1'b0;
        o_data[l]  <= '0;
      end else begin
        o_valid[l] <= f_valid && ins.d_en[l];
        o_tag[l]   <= ins.d_tag[l];
        o_port[l]  <= ins.d_port[l];
        o_data[l]  <= result;
      end
    end
  end

  p_result_after_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|o_valid) |-> $past(f_valid));
endmodule

// File: rtl/dfm_unit.sv
module dfm_unit
  import dfm_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tok_valid,
  input  logic [TAG_W-1:0]          tok_tag,
  input  logic                      tok_port,
  input  logic [DATA_W-1:0]         tok_data,
  output logic                      tok_ready,
  input  logic                      pw_en,
  input  logic [TAG_W-1:0]          pw_addr,
  input  logic [1:0]                pw_op,
  input  logic                      pw_imm_en,
  input  logic [DATA_W-1:0]         pw_imm,
  input  logic [NLANE-1:0]          pw_dst_en,
  input  logic [NLANE*TAG_W-1:0]    pw_dst_tag,
  input  logic [NLANE-1:0]          pw_dst_port,
  output logic [NLANE-1:0]          res_valid,
  output logic [NLANE*TAG_W-1:0]    res_tag,
  output logic [NLANE-1:0]          res_port,
  output logic [NLANE*DATA_W-1:0]   res_data,
  output logic                      dup_err
);
  instr_t pw_word, in_ins, f_ins;
  logic   hit, dup, full;
  logic [DATA_W-1:0] hit_data;
  logic [CW-1:0]     occ;

  // Named internal events
  logic need_park, acc, ev_imm, ev_dup, ev_pair, ev_park;

  logic              f_valid;
  logic [TAG_W-1:0]  f_tag;
  logic [DATA_W-1:0] f_a, f_b;

  always_comb begin
    pw_word.op     = op_e'(pw_op);
    pw_word.imm_en = pw_imm_en;
    pw_word.imm    = pw_imm;
    pw_word.d_en   = pw_dst_en;
    pw_word.d_tag  = pw_dst_tag;
    pw_word.d_port = pw_dst_port;
  end

  dfm_prog_store u_prog (
    .clk     (clk),
    .wr_en   (pw_en),
    .wr_addr (pw_addr),
    .wr_data (pw_word),
    .ra_addr (tok_tag),
    .ra_data (in_ins),
    .rb_addr (f_tag),
    .rb_data (f_ins)
  );

  dfm_match_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_tag    (tok_tag),
    .q_port   (tok_port),
    .q_data   (tok_data),
    .ins_en   (ev_park),
    .rm_en    (ev_pair),
    .hit      (hit),
    .dup      (dup),
    .hit_data (hit_data),
    .full     (full),
    .occ      (occ)
  );

  assign need_park = !in_ins.imm_en && !hit && !dup;
  assign tok_ready = !(need_park && full);
  assign acc       = tok_valid && tok_ready;
  assign ev_imm    = acc && in_ins.imm_en;
  assign ev_dup    = acc && !in_ins.imm_en && dup;
  assign ev_pair   = acc && !in_ins.imm_en && !dup && hit;
  assign ev_park   = acc && need_park;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_valid <= 1'b0;
      f_tag   <= '0;
      f_a     <= '0;
      f_b     <= '0;
      dup_err <= 1'b0;
    end else begin
      f_valid <= ev_imm || ev_pair;
      f_tag   <= tok_tag;
      if (ev_imm) begin
        f_a <= tok_data;
        f_b <= in_ins.imm;
      end else begin
        f_a <= tok_port ? hit_data : tok_data;
        f_b <= tok_port ? tok_data : hit_data;
      end
      if (ev_dup) dup_err <= 1'b1;
    end
  end

  dfm_exec u_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .f_valid (f_valid),
    .f_a     (f_a),
    .f_b     (f_b),
    .ins     (f_ins),
    .o_valid (res_valid),
    .o_tag   (res_tag),
    .o_port  (res_port),
    .o_data  (res_data)
  );

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |=> dup_err);
  p_dup_keeps_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dup |=> occ == $past(occ));
  p_stall_needs_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_ready |-> full);
  p_imm_keeps_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_imm |=> occ == $past(occ));
endmodule

// File: tb/tb_dfm_unit.sv
`timescale 1ns/1ps
module tb_dfm_unit;
  localparam int SINK = 30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tok_valid;
  logic [4:0]  tok_tag;
  logic        tok_port;
  logic [15:0] tok_data;
  logic        tok_ready;
  logic        pw_en;
  logic [4:0]  pw_addr;
  logic [1:0]  pw_op;
  logic        pw_imm_en;
  logic [15:0] pw_imm;
  logic [1:0]  pw_dst_en;
  logic [9:0]  pw_dst_tag;
  logic [1:0]  pw_dst_port;
  logic [1:0]  res_valid;
  logic [9:0]  res_tag;
  logic [1:0]  res_port;
  logic [31:0] res_data;
  logic        dup_err;

  always #2.5 clk = ~clk;

  dfm_unit dut (.*);

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  typedef struct {int tag; int port; int data;} tok_t;
  tok_t wq[$];
  tok_t pend[$];
  int   sinkq[$];

  int m_op[32], m_ie[32], m_imm[32];
  int m_den[32][2], m_dtag[32][2], m_dport[32][2];
  int ef_v, ef_tag, ef_a, ef_b;
  int eo_v[2], eo_tag[2], eo_port[2], eo_data[2];
  int exp_err;

  task automatic check(bit ok, string what, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  function automatic int ref_op(int op, int a, int b);
    longint r;
    case (op)
      0: r = longint'(a) + b;
      1: r = longint'(a) - b;
      2: r = longint'(a) * b;
      default: r = a;
    endcase
    return int'(r & 64'hFFFF);
  endfunction

  task automatic pgm(int addr, int op, int ie, int imm,
                     int en0, int t0, int p0, int en1, int t1, int p1);
    @(negedge clk);
    pw_en = 1; pw_addr = 5'(addr); pw_op = 2'(op); pw_imm_en = ie[0];
    pw_imm = 16'(imm); pw_dst_en = {en1[0], en0[0]};
    pw_dst_tag = {5'(t1), 5'(t0)}; pw_dst_port = {p1[0], p0[0]};
    m_op[addr] = op; m_ie[addr] = ie; m_imm[addr] = imm;
    m_den[addr][0] = en0; m_dtag[addr][0] = t0; m_dport[addr][0] = p0;
    m_den[addr][1] = en1; m_dtag[addr][1] = t1; m_dport[addr][1] = p1;
    @(posedge clk);
    #1 pw_en = 0;
  endtask

  // One clock: compare outputs of the previous edge, drive a token, step the model.
  task automatic cyc(bit v, int tag, int port, int data, output bit acc);
    int hi, di;
    bit need, rdy;
    @(negedge clk);
    for (int l = 0; l < 2; l++) begin
      check(res_valid[l] == eo_v[l][0], "R3 R6 lane valid timing", res_valid[l], eo_v[l]);
      if (eo_v[l] != 0) begin
        check(res_data[l*16 +: 16] == 16'(eo_data[l]), "R4 result value",
              res_data[l*16 +: 16], eo_data[l]);
        check(res_tag[l*5 +: 5] == 5'(eo_tag[l]) && res_port[l] == eo_port[l][0],
              "R6 lane destination", res_tag[l*5 +: 5], eo_tag[l]);
        if (eo_tag[l] >= SINK) sinkq.push_back(eo_data[l]);
        else pend.push_back('{eo_tag[l], eo_port[l], eo_data[l]});
      end
    end
    check(dup_err == exp_err[0], "R8 error flag", dup_err, exp_err);
    tok_valid = v; tok_tag = 5'(tag); tok_port = port[0]; tok_data = 16'(data);
    hi = -1; di = -1;
    for (int i = 0; i < wq.size(); i++) begin
      if (wq[i].tag == tag && wq[i].port != port) hi = i;
      if (wq[i].tag == tag && wq[i].port == port) di = i;
    end
    need = (m_ie[tag] == 0) && hi < 0 && di < 0;
    rdy  = !(need && wq.size() == 16);
    #1;
    if (v) check(tok_ready == rdy, "R7 input ready", tok_ready, rdy);
    acc = v && rdy;
    for (int l = 0; l < 2; l++) begin
      eo_v[l] = ef_v && m_den[ef_tag][l];
      eo_tag[l] = m_dtag[ef_tag][l]; eo_port[l] = m_dport[ef_tag][l];
      eo_data[l] = ref_op(m_op[ef_tag], ef_a, ef_b);
    end
    ef_v = 0;
    if (acc) begin
      if (m_ie[tag] != 0) begin
        ef_v = 1; ef_tag = tag; ef_a = data; ef_b = m_imm[tag];
      end else if (di >= 0) begin
        exp_err = 1;
      end else if (hi >= 0) begin
        ef_v = 1; ef_tag = tag;
        ef_a = port ? wq[hi].data : data;
        ef_b = port ? data : wq[hi].data;
        wq.delete(hi);
      end else begin
        wq.push_back('{tag, port, data});
      end
    end
    @(posedge clk);
  endtask

  task automatic run();
    int idle = 0;
    bit acc;
    for (int it = 0; it < 3000 && idle < 4; it++) begin
      if (pend.size() > 0) begin
        idle = 0;
        cyc(1, pend[0].tag, pend[0].port, pend[0].data, acc);
        if (acc) void'(pend.pop_front());
      end else begin
        idle++;
        cyc(0, 0, 0, 0, acc);
      end
    end
  endtask

  task automatic graph(int b, int c, int e, bit late_b);
    int a, d, f;
    sinkq.delete();
    if (!late_b) begin pend.push_back('{0, 0, b}); pend.push_back('{1, 0, b}); end
    pend.push_back('{1, 1, c}); pend.push_back('{3, 0, c}); pend.push_back('{3, 1, e});
    if (late_b) begin pend.push_back('{0, 0, b}); pend.push_back('{1, 0, b}); end
    run();
    a = ref_op(2, ref_op(0, b, 1), ref_op(1, b, c));
    d = ref_op(2, c, e);
    f = ref_op(2, a, d);
    check(sinkq.size() == 1, "R9 one final token", sinkq.size(), 1);
    if (sinkq.size() == 1) check(sinkq[0] == f, "R9 graph result f", sinkq[0], f);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit acc;
    rst_n = 0; tok_valid = 0; tok_tag = 0; tok_port = 0; tok_data = 0;
    pw_en = 0; pw_addr = 0; pw_op = 0; pw_imm_en = 0; pw_imm = 0;
    pw_dst_en = 0; pw_dst_tag = 0; pw_dst_port = 0;
    ef_v = 0; exp_err = 0; ef_tag = 0; ef_a = 0; ef_b = 0;
    for (int l = 0; l < 2; l++) begin eo_v[l] = 0; eo_tag[l] = 0; eo_port[l] = 0; eo_data[l] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(res_valid == 2'b00, "R1 reset outputs idle", res_valid, 0);
    check(dup_err == 1'b0, "R1 reset error clear", dup_err, 0);

    for (int t = 0; t < 32; t++) pgm(t, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check(tok_ready == 1'b1, "R1 ready with empty store", tok_ready, 1);

    // Graph: a=(b+1)*(b-c), d=c*e, f=a*d
    pgm(0, 0, 1, 1, 1, 2, 0, 0, 0, 0);
    pgm(1, 1, 0, 0, 1, 2, 1, 0, 0, 0);
    pgm(2, 2, 0, 0, 1, 4, 0, 0, 0, 0);
    pgm(3, 2, 0, 0, 1, 4, 1, 0, 0, 0);
    pgm(4, 2, 0, 0, 1, 31, 0, 0, 0, 0);
    graph(5, 2, 3, 0);
    graph(300, 7, 250, 1);
    graph(4, 9, 11, 0);

    // R5: immediate instruction fires on a lone token
    pgm(8, 1, 1, 100, 1, 31, 0, 0, 0, 0);
    sinkq.delete();
    pend.push_back('{8, 1, 130});
    run();
    check(sinkq.size() == 1 && sinkq[0] == 30, "R5 immediate fire", sinkq.size() > 0 ? sinkq[0] : -1, 30);

    // R6 R4: subtract with both lanes, right operand first; pass opcode
    pgm(9, 1, 0, 0, 1, 31, 0, 1, 30, 1);
    pgm(11, 3, 0, 0, 0, 0, 0, 1, 31, 1);
    sinkq.delete();
    cyc(1, 9, 1, 3, acc);
    cyc(1, 9, 0, 10, acc);
    cyc(1, 11, 1, 77, acc);
    cyc(1, 11, 0, 55, acc);
    run();
    check(sinkq.size() == 3, "R6 lane count", sinkq.size(), 3);
    if (sinkq.size() == 3) begin
      check(sinkq[0] == 7 && sinkq[1] == 7, "R4 first minus second", sinkq[0], 7);
      check(sinkq[2] == 55, "R4 pass first operand", sinkq[2], 55);
    end

    // R2 R8: park, duplicate, then partner
    pgm(12, 2, 0, 0, 1, 31, 0, 0, 0, 0);
    sinkq.delete();
    cyc(1, 12, 0, 4, acc);
    cyc(0, 0, 0, 0, acc);
    cyc(0, 0, 0, 0, acc);
    check(sinkq.size() == 0, "R2 lone token parked", sinkq.size(), 0);
    cyc(1, 12, 0, 9, acc);
    cyc(0, 0, 0, 0, acc);
    check(dup_err == 1'b1, "R8 duplicate flagged", dup_err, 1);
    cyc(1, 12, 1, 5, acc);
    run();
    check(sinkq.size() == 1 && sinkq[0] == 20, "R8 waiting token kept", sinkq.size() > 0 ? sinkq[0] : -1, 20);
    check(dup_err == 1'b1, "R8 flag sticky", dup_err, 1);

    // R7: fill store to capacity
    for (int t = 13; t < 30; t++) pgm(t, 0, 0, 0, 1, 31, 0, 0, 0, 0);
    sinkq.delete();
    for (int t = 13; t < 29; t++) cyc(1, t, 0, t, acc);
    cyc(1, 29, 0, 99, acc);
    check(acc == 0, "R7 stall when full", acc, 0);
    check(tok_ready == 1'b0, "R7 ready low when full", tok_ready, 0);
    cyc(1, 8, 0, 1, acc);
    check(acc == 1, "R7 immediate accepted while full", acc, 1);
    cyc(1, 13, 1, 1, acc);
    check(acc == 1, "R7 match accepted while full", acc, 1);
    cyc(1, 29, 0, 99, acc);
    check(acc == 1, "R7 park after space frees", acc, 1);
    for (int t = 14; t < 30; t++) pend.push_back('{t, 1, 1});
    run();
    check(sinkq.size() == 18, "R7 all tokens drained", sinkq.size(), 18);
    if (sinkq.size() == 18) check(sinkq[1] == 14, "R7 first pair sum", sinkq[1], 14);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule